// File: doc/BRIEF.md
# Register-Window AXI4-Lite Single-Transfer Bridge

This block lets a host with a narrow 16-bit register port reach a 32-bit AXI4-Lite memory-mapped bus one transfer at a time. Software loads the target address and, for writes, the data as two 16-bit halves each, then writes a command code into the low nibble of the control register. The bridge runs exactly one AXI4-Lite read or write, guards it with a response timeout, and reports the outcome through sticky write-one-to-clear event flags in the status register.

Read and write each have a variant that moves the address register forward by one word after a successful transfer, so a driver can walk a region without reloading the address. An interrupt output combines the event flags and a downstream interrupt line, each gated by its own enable bit in the control register.

Top module: `hwab_top`

## Requirements
- R1: The host window has eight 16-bit registers selected by `host_word` (byte offset divided by two): 0 status, 1 control, 2 address low half, 3 address high half, 4 write data low half, 5 write data high half, 6 read data low half, 7 read data high half; words 1 to 5 read back what was written (control reads as enables in [15:11], the last accepted command in [3:0], zeros elsewhere).
- R2: A control write with [3:0] equal to 0x8 starts a write, 0x9 a write with address post-increment, 0xA a read, 0xB a read with address post-increment; any other code, including 0x0, starts no transfer.
- R3: A write drives address {word 3, word 2} and data {word 5, word 4} with all byte strobes set; an OKAY response sets status bit 14 (write complete).
- R4: A read drives address {word 3, word 2}; on an OKAY response the returned data is shown with its upper half at word 7 and lower half at word 6, and status bits 15 (read complete) and 7 (read data available) are set.
- R5: A SLVERR or DECERR response (resp bit 1 set) sets status bit 12 (error) and no completion bit, and leaves read data and bit 7 unchanged.
- R6: If no response is completed within TMO_CYC clock cycles of acceptance, status bit 13 (timeout) is set, all valid/ready outputs drop and the bridge returns to idle.
- R7: Status bit 6 (busy) is high from the cycle after a command is accepted until the cycle its single outcome event (one of bits 15, 14, 13, 12) is set.
- R8: Status bits 15:12 are sticky; writing status with a one in any of those positions clears that bit and a zero leaves it unchanged.
- R9: A post-increment command adds ADDR_STEP (default 4) to the 32-bit address, carrying from the low half into the high half, only after an OKAY response.
- R10: A command written while busy is high starts nothing and does not change the stored command.
- R11: Reading word 7 clears status bit 7; reading word 6 does not.
- R12: Status bit 11 mirrors `axi_irq_in` after IRQ_SYNC flops; `irq` is high exactly when some status bit among 15:11 and its enable in control bits 15:11 are both high.
- R13: After reset all registers are zero and status bit 5 (init done) rises on the first clock after reset is released.
- R14: Each AXI valid stays high with stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 3 | Register index (byte offset / 2) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the cycle of the access |
| irq | output | 1 | Enabled-event interrupt |
| axi_irq_in | input | 1 | Downstream interrupt line |
| m_awaddr | output | 32 | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A corrupted address or increment register shows up at the bus on the very next command as a wrong address, and at the host at once when word 2 or 3 is read back. A wrong outcome decode or a lost response leaves the wrong event bit set, or busy stuck until the timeout fires TMO_CYC cycles later. Errors in the sticky clear or the read-data-available flag are visible in the next status read. The bench drives the slave side with random ready delays and response codes and compares every result against a software model of the register file.

// File: rtl/hwab_pkg.sv
package hwab_pkg;
   localparam int REG_W  = 16;
   localparam int BUS_W  = 2 * REG_W;

   // register word indices; software decodes these
   localparam logic [2:0] W_STAT  = 3'd0;
   localparam logic [2:0] W_CTRL  = 3'd1;
   localparam logic [2:0] W_ADRLO = 3'd2;
   localparam logic [2:0] W_ADRHI = 3'd3;
   localparam logic [2:0] W_WDLO  = 3'd4;
   localparam logic [2:0] W_WDHI  = 3'd5;
   localparam logic [2:0] W_RDLO  = 3'd6;
   localparam logic [2:0] W_RDHI  = 3'd7;

   // outcome of one transfer
   typedef enum logic [1:0] {
      RES_OK  = 2'd0,
      RES_ERR = 2'd1,
      RES_TMO = 2'd2
   } res_e;

   // sticky flags, packed in status order 15..12
   typedef struct packed {
      logic rd_done;
      logic wr_done;
      logic tmo;
      logic err;
   } evt_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WR_REQ,
      S_WR_RSP,
      S_RD_REQ,
      S_RD_RSP
   } st_e;
endpackage

// File: rtl/hwab_axi_master.sv
module hwab_axi_master
   import hwab_pkg::*;
#(
   parameter int TMO_CYC = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             is_read_i,
   input  logic [BUS_W-1:0] addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic             done_o,
   output res_e             res_o,
   output logic [BUS_W-1:0] rdata_o,
   output logic [BUS_W-1:0] m_awaddr,
   output logic             m_awvalid,
   input  logic             m_awready,
   output logic [BUS_W-1:0] m_wdata,
   output logic [BUS_W/8-1:0] m_wstrb,
   output logic             m_wvalid,
   input  logic             m_wready,
   input  logic [1:0]       m_bresp,
   input  logic             m_bvalid,
   output logic             m_bready,
   output logic [BUS_W-1:0] m_araddr,
   output logic             m_arvalid,
   input  logic             m_arready,
   input  logic [BUS_W-1:0] m_rdata,
   input  logic [1:0]       m_rresp,
   input  logic             m_rvalid,
   output logic             m_rready
);
   localparam int CNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC + 1) : 1;

   st_e              st_q;
   logic             aw_pend_q, w_pend_q;
   logic [BUS_W-1:0] addr_q, wd_q;
   logic             tmo_hit;

   assign m_awaddr  = addr_q;
   assign m_araddr  = addr_q;
   assign m_wdata   = wd_q;
   assign m_wstrb   = '1;
   assign m_awvalid = (st_q == S_WR_REQ) && aw_pend_q;
   assign m_wvalid  = (st_q == S_WR_REQ) && w_pend_q;
   assign m_bready  = (st_q == S_WR_RSP);
   assign m_arvalid = (st_q == S_RD_REQ);
   assign m_rready  = (st_q == S_RD_RSP);

   // response timeout: a counter variant or none at all
   generate
      if (TMO_CYC > 0) begin : g_tmo
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (st_q == S_IDLE)   cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
         assign tmo_hit = (st_q != S_IDLE) && (cnt_q == CNT_W'(TMO_CYC - 1));
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   function automatic res_e resp_dec(input logic [1:0] r);
      return (r == 2'b10 || r == 2'b11) ? RES_ERR : RES_OK;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         aw_pend_q <= 1'b0;
         w_pend_q  <= 1'b0;
         addr_q    <= '0;
         wd_q      <= '0;
         done_o    <= 1'b0;
         res_o     <= RES_OK;
         rdata_o   <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  addr_q    <= addr_i;
                  wd_q      <= wdata_i;
                  aw_pend_q <= !is_read_i;
                  w_pend_q  <= !is_read_i;
                  st_q      <= is_read_i ? S_RD_REQ : S_WR_REQ;
               end
            end
            S_WR_REQ: begin
               if (m_awready) aw_pend_q <= 1'b0;
               if (m_wready)  w_pend_q  <= 1'b0;
               if ((!aw_pend_q || m_awready) && (!w_pend_q || m_wready))
                  st_q <= S_WR_RSP;
               else if (tmo_hit) begin
                  st_q   <= S_IDLE;
                  done_o <= 1'b1;
                  res_o  <= RES_TMO;
               end
            end
            S_WR_RSP: begin
               if (m_bvalid) begin
                  st_q   <= S_IDLE;
                  done_o <= 1'b1;
                  res_o  <= resp_dec(m_bresp);
               end else if (tmo_hit) begin
                  st_q   <= S_IDLE;
                  done_o <= 1'b1;
                  res_o  <= RES_TMO;
               end
            end
            S_RD_REQ: begin
               if (m_arready) st_q <= S_RD_RSP;
               else if (tmo_hit) begin
                  st_q   <= S_IDLE;
                  done_o <= 1'b1;
                  res_o  <= RES_TMO;
               end
            end
            S_RD_RSP: begin
               if (m_rvalid) begin
                  st_q    <= S_IDLE;
                  done_o  <= 1'b1;
                  res_o   <= resp_dec(m_rresp);
                  rdata_o <= m_rdata;
               end else if (tmo_hit) begin
                  st_q   <= S_IDLE;
                  done_o <= 1'b1;
                  res_o  <= RES_TMO;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // R10: the register file never launches while a transfer is in flight
   a_r10_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (st_q == S_IDLE));
   // R14: request channels hold until accepted
   a_r14_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready && !tmo_hit) |=> (m_arvalid && $stable(m_araddr)));
   a_r14_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready && !tmo_hit) |=> (m_awvalid && $stable(m_awaddr)));
   a_r14_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready && !tmo_hit) |=> (m_wvalid && $stable(m_wdata)));
   // R7: one outcome per transfer, reported as a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R6: after a timeout nothing on the bus is left asserted
   a_r6_tmo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && res_o == RES_TMO) |-> !(m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready));
endmodule

// File: rtl/hwab_regs.sv
module hwab_regs
   import hwab_pkg::*;
#(
   parameter int ADDR_STEP = 4,
   parameter int IRQ_SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic             host_we,
   input  logic [2:0]       host_word,
   input  logic [REG_W-1:0] host_wdata,
   output logic [REG_W-1:0] host_rdata,
   output logic             start_o,
   output logic             is_read_o,
   output logic [BUS_W-1:0] addr_o,
   output logic [BUS_W-1:0] wdata_o,
   input  logic             done_i,
   input  res_e             res_i,
   input  logic [BUS_W-1:0] rdata_i,
   input  logic             axi_irq_i,
   output logic             irq_o
);
   localparam int EN_W = 5;

   logic [EN_W-1:0]  en_q;
   logic [3:0]       cmd_q;
   logic [BUS_W-1:0] addr_q, wd_q, rd_q;
   evt_t             evt_q;
   logic             rdav_q, busy_q, init_q, inc_q, isrd_q;
   logic             irq_s;

   wire wr_acc = host_req && host_we;
   wire rd_acc = host_req && !host_we;
   wire adr_wr = wr_acc && (host_word == W_ADRLO || host_word == W_ADRHI);
   wire rd_hi  = rd_acc && (host_word == W_RDHI);
   wire accept = wr_acc && (host_word == W_CTRL) && !busy_q && (host_wdata[3:2] == 2'b10);

   assign start_o   = accept;
   assign is_read_o = host_wdata[1];
   assign addr_o    = addr_q;
   assign wdata_o   = wd_q;

   // downstream interrupt: direct or resynchronised
   generate
      if (IRQ_SYNC > 0) begin : g_sync
         logic [IRQ_SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[IRQ_SYNC-2:0], axi_irq_i};
         end
         assign irq_s = sh_q[IRQ_SYNC-1];
      end else begin : g_direct
         assign irq_s = axi_irq_i;
      end
   endgenerate

   logic [BUS_W-1:0] addr_n;
   evt_t             evt_n;

   always_comb begin
      addr_n = addr_q;
      if (done_i && res_i == RES_OK && inc_q)
         addr_n = addr_q + BUS_W'(ADDR_STEP);
      if (wr_acc && host_word == W_ADRLO) addr_n[REG_W-1:0]     = host_wdata;
      if (wr_acc && host_word == W_ADRHI) addr_n[BUS_W-1:REG_W] = host_wdata;

      evt_n = evt_q;
      if (wr_acc && host_word == W_STAT)
         evt_n = evt_q & ~evt_t'(host_wdata[15:12]);
      if (done_i) begin
         unique case (res_i)
            RES_OK:  if (isrd_q) evt_n.rd_done = 1'b1; else evt_n.wr_done = 1'b1;
            RES_ERR: evt_n.err = 1'b1;
            default: evt_n.tmo = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         cmd_q  <= '0;
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
         evt_q  <= '0;
         rdav_q <= 1'b0;
         busy_q <= 1'b0;
         init_q <= 1'b0;
         inc_q  <= 1'b0;
         isrd_q <= 1'b0;
      end else begin
         init_q <= 1'b1;
         addr_q <= addr_n;
         evt_q  <= evt_n;
         if (wr_acc && host_word == W_CTRL) en_q <= host_wdata[15:11];
         if (wr_acc && host_word == W_WDLO) wd_q[REG_W-1:0]     <= host_wdata;
         if (wr_acc && host_word == W_WDHI) wd_q[BUS_W-1:REG_W] <= host_wdata;
         if (accept) begin
            cmd_q  <= host_wdata[3:0];
            inc_q  <= host_wdata[0];
            isrd_q <= host_wdata[1];
            busy_q <= 1'b1;
         end else if (done_i) begin
            busy_q <= 1'b0;
         end
         if (done_i && res_i == RES_OK && isrd_q) begin
            rd_q   <= rdata_i;
            rdav_q <= 1'b1;
         end else if (rd_hi) begin
            rdav_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (host_word)
         W_STAT:  host_rdata = {evt_q, irq_s, 3'b000, rdav_q, busy_q, init_q, 5'b00000};
         W_CTRL:  host_rdata = {en_q, 7'b0000000, cmd_q};
         W_ADRLO: host_rdata = addr_q[REG_W-1:0];
         W_ADRHI: host_rdata = addr_q[BUS_W-1:REG_W];
         W_WDLO:  host_rdata = wd_q[REG_W-1:0];
         W_WDHI:  host_rdata = wd_q[BUS_W-1:REG_W];
         W_RDLO:  host_rdata = rd_q[REG_W-1:0];
         default: host_rdata = rd_q[BUS_W-1:REG_W];
      endcase
   end

   assign irq_o = |({evt_q, irq_s} & en_q);

   // R7: busy only falls on the cycle an outcome arrives
   a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(done_i));
   // R9: successful post-increment advances the address by one step
   a_r9_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && res_i == RES_OK && inc_q && !adr_wr) |=> (addr_q == $past(addr_q) + BUS_W'(ADDR_STEP)));
   // R9: failed transfers leave the address alone
   a_r9_no_inc_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && res_i != RES_OK && !adr_wr) |=> $stable(addr_q));
   // R8: flags only change through a status write or an outcome
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_acc && host_word == W_STAT) && !done_i) |=> $stable(evt_q));
   // R11: reading the upper read-data half clears data-available
   a_r11_rdav_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !done_i) |=> !rdav_q);
   // R12: no enables, no interrupt
   a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_o);
   // R13: init done rises right after reset and stays
   a_r13_init: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> init_q);
endmodule

// File: rtl/hwab_top.sv
module hwab_top
   import hwab_pkg::*;
#(
   parameter int TMO_CYC   = 1024,
   parameter int ADDR_STEP = 4,
   parameter int IRQ_SYNC  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_req,
   input  logic        host_we,
   input  logic [2:0]  host_word,
   input  logic [15:0] host_wdata,
   output logic [15:0] host_rdata,
   output logic        irq,
   input  logic        axi_irq_in,
   output logic [31:0] m_awaddr,
   output logic        m_awvalid,
   input  logic        m_awready,
   output logic [31:0] m_wdata,
   output logic [3:0]  m_wstrb,
   output logic        m_wvalid,
   input  logic        m_wready,
   input  logic [1:0]  m_bresp,
   input  logic        m_bvalid,
   output logic        m_bready,
   output logic [31:0] m_araddr,
   output logic        m_arvalid,
   input  logic        m_arready,
   input  logic [31:0] m_rdata,
   input  logic [1:0]  m_rresp,
   input  logic        m_rvalid,
   output logic        m_rready
);
   generate
      if (REG_W != 16 || BUS_W != 32) begin : g_bad_width
         $error("hwab_top: status bit layout needs a 16-bit window");
      end
      if (TMO_CYC < 0 || TMO_CYC > 1000000) begin : g_bad_tmo
         $error("hwab_top: TMO_CYC out of range");
      end
      if (ADDR_STEP <= 0 || (ADDR_STEP & (ADDR_STEP - 1)) != 0) begin : g_bad_step
         $error("hwab_top: ADDR_STEP must be a power of two");
      end
      if (IRQ_SYNC == 1 || IRQ_SYNC > 4) begin : g_bad_sync
         $error("hwab_top: IRQ_SYNC must be 0, 2, 3 or 4");
      end
   endgenerate

   logic             start, is_read, done;
   res_e             res;
   logic [BUS_W-1:0] addr, wdata, rdata;

   hwab_regs #(
      .ADDR_STEP (ADDR_STEP),
      .IRQ_SYNC  (IRQ_SYNC)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req   (host_req),
      .host_we    (host_we),
      .host_word  (host_word),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .start_o    (start),
      .is_read_o  (is_read),
      .addr_o     (addr),
      .wdata_o    (wdata),
      .done_i     (done),
      .res_i      (res),
      .rdata_i    (rdata),
      .axi_irq_i  (axi_irq_in),
      .irq_o      (irq)
   );

   hwab_axi_master #(
      .TMO_CYC (TMO_CYC)
   ) u_axi (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .is_read_i (is_read),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .done_o    (done),
      .res_o     (res),
      .rdata_o   (rdata),
      .m_awaddr  (m_awaddr),
      .m_awvalid (m_awvalid),
      .m_awready (m_awready),
      .m_wdata   (m_wdata),
      .m_wstrb   (m_wstrb),
      .m_wvalid  (m_wvalid),
      .m_wready  (m_wready),
      .m_bresp   (m_bresp),
      .m_bvalid  (m_bvalid),
      .m_bready  (m_bready),
      .m_araddr  (m_araddr),
      .m_arvalid (m_arvalid),
      .m_arready (m_arready),
      .m_rdata   (m_rdata),
      .m_rresp   (m_rresp),
      .m_rvalid  (m_rvalid),
      .m_rready  (m_rready)
   );
endmodule

// File: tb/hwab_top_tb.sv
module hwab_top_tb;
   localparam int TMO = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [2:0]  host_word = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        irq, axi_irq_in = 1'b0;
   logic [31:0] m_awaddr, m_wdata, m_araddr;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
   logic        m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
   logic [1:0]  m_bresp, m_rresp;
   logic [31:0] m_rdata;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #10 clk = ~clk;

   hwab_top u_dut (.*);

   // ---------------- slave model ----------------
   logic        s_mute = 1'b0;
   logic [1:0]  s_resp = 2'b00;
   logic        got_aw, got_w, got_ar;
   logic [31:0] cap_aw, cap_w, cap_ar;
   logic [3:0]  cap_strb;
   int          wr_cnt, rd_cnt, awv_cnt;

   function automatic logic [31:0] mix(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_awready <= 0; m_wready <= 0; m_arready <= 0;
         m_bvalid <= 0; m_rvalid <= 0; m_bresp <= 0; m_rresp <= 0; m_rdata <= 0;
         got_aw <= 0; got_w <= 0; got_ar <= 0;
         cap_aw <= 0; cap_w <= 0; cap_ar <= 0; cap_strb <= 0;
         wr_cnt <= 0; rd_cnt <= 0; awv_cnt <= 0;
      end else begin
         m_awready <= !s_mute && ($urandom % 2 == 0);
         m_wready  <= !s_mute && ($urandom % 2 == 0);
         m_arready <= !s_mute && ($urandom % 2 == 0);
         if (m_awvalid) awv_cnt <= awv_cnt + 1;
         if (m_awvalid && m_awready) begin got_aw <= 1; cap_aw <= m_awaddr; end
         if (m_wvalid && m_wready) begin got_w <= 1; cap_w <= m_wdata; cap_strb <= m_wstrb; end
         if (got_aw && got_w && !m_bvalid && ($urandom % 3 != 0)) begin
            m_bvalid <= 1; m_bresp <= s_resp; got_aw <= 0; got_w <= 0; wr_cnt <= wr_cnt + 1;
         end
         if (m_bvalid && m_bready) m_bvalid <= 0;
         if (m_arvalid && m_arready) begin got_ar <= 1; cap_ar <= m_araddr; end
         if (got_ar && !m_rvalid && ($urandom % 3 != 0)) begin
            m_rvalid <= 1; m_rresp <= s_resp; m_rdata <= mix(cap_ar); got_ar <= 0; rd_cnt <= rd_cnt + 1;
         end
         if (m_rvalid && m_rready) m_rvalid <= 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [2:0] w, input logic [15:0] d);
      @(negedge clk);
      host_req = 1; host_we = 1; host_word = w; host_wdata = d;
      @(negedge clk);
      host_req = 0; host_we = 0;
   endtask

   task automatic hr(input logic [2:0] w, output logic [15:0] d);
      @(negedge clk);
      host_req = 1; host_we = 0; host_word = w;
      #1 d = host_rdata;
      @(posedge clk);
      #1 host_req = 0;
   endtask

   // model state
   logic [31:0] m_addr = 0, m_rd = 0;
   logic        m_rdav = 0;
   logic [4:0]  en_cfg = 0;

   // wait for busy low; returns polls taken and whether busy was seen high
   task automatic wait_idle(output int polls, output logic saw_busy);
      logic [15:0] s;
      polls = 0; saw_busy = 0;
      forever begin
         hr(3'd0, s);
         polls++;
         if (s[6]) saw_busy = 1;
         if (!s[6] || polls > 3000) break;
      end
   endtask

   task automatic set_addr(input logic [31:0] a);
      hw(3'd2, a[15:0]); hw(3'd3, a[31:16]); m_addr = a;
   endtask

   // run one command and check everything against the model
   task automatic run(input logic [3:0] cmd, input logic [31:0] wd, input logic [1:0] resp);
      int p; logic sb; logic [15:0] s, lo, hi;
      logic is_rd, inc, err;
      is_rd = cmd[1]; inc = cmd[0]; err = resp[1];
      s_resp = resp;
      hw(3'd4, wd[15:0]); hw(3'd5, wd[31:16]);
      hw(3'd0, 16'hF000);
      hw(3'd1, {en_cfg, 7'd0, cmd});
      wait_idle(p, sb);
      chk("R7 busy seen after accept", {31'd0, sb}, 32'd1);
      hr(3'd0, s);
      if (!is_rd) begin
         chk("R3 awaddr", cap_aw, m_addr);
         chk("R3 wdata", cap_w, wd);
         chk("R3 wstrb", {28'd0, cap_strb}, 32'hF);
      end else begin
         chk("R4 araddr", cap_ar, m_addr);
      end
      if (err) chk("R5 events", {16'd0, s[15:12]}, 32'h1);
      else     chk(is_rd ? "R4 events" : "R3 events", {16'd0, s[15:12]}, is_rd ? 32'h8 : 32'h4);
      if (is_rd && !err) begin m_rd = mix(m_addr); m_rdav = 1; end
      chk("R4 R5 read-avail", {31'd0, s[7]}, {31'd0, m_rdav});
      if (inc && !err) m_addr = m_addr + 4;
      hr(3'd2, lo); hr(3'd3, hi);
      chk("R9 address after command", {hi, lo}, m_addr);
      hr(3'd6, lo); hr(3'd7, hi); m_rdav = 0;
      chk("R4 R5 read data", {hi, lo}, m_rd);
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] s, c, lo, hi;
      int p, wc, rc, av; logic sb;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R13 status during reset", {16'd0, host_rdata}, 32'h0);
      rst_n = 1;
      hr(3'd0, s);
      chk("R13 status after reset", {16'd0, s}, 32'h0020);
      hr(3'd1, c);
      chk("R13 control after reset", {16'd0, c}, 32'h0);
      chk("R12 irq after reset", {31'd0, irq}, 32'd0);

      // R1 readback
      hw(3'd2, 16'h1234); hw(3'd3, 16'hABCD); hw(3'd4, 16'h5566); hw(3'd5, 16'h7788);
      hr(3'd2, lo); hr(3'd3, hi);
      chk("R1 address readback", {hi, lo}, 32'hABCD1234);
      hr(3'd4, lo); hr(3'd5, hi);
      chk("R1 write data readback", {hi, lo}, 32'h77885566);
      m_addr = 32'hABCD1234;

      // R2 codes that start nothing
      wc = wr_cnt; rc = rd_cnt;
      hw(3'd1, 16'h0005); hw(3'd1, 16'h000C); hw(3'd1, 16'h0000);
      repeat (8) @(negedge clk);
      hr(3'd0, s);
      chk("R2 no busy from invalid codes", {31'd0, s[6]}, 32'd0);
      chk("R2 no transfer from invalid codes", wr_cnt + rd_cnt, wc + rc);

      // directed write / read
      set_addr(32'h0000_1000);
      run(4'h8, 32'hDEADBEEF, 2'b00);
      run(4'hA, 32'h0, 2'b00);
      // R11: low half read keeps flag, high half clears
      hw(3'd0, 16'hF000);
      hw(3'd1, 16'h000A);
      wait_idle(p, sb);
      m_rd = mix(m_addr);
      hr(3'd6, lo); hr(3'd0, s);
      chk("R11 low-half read keeps flag", {31'd0, s[7]}, 32'd1);
      hr(3'd7, hi); hr(3'd0, s);
      chk("R11 high-half read clears flag", {31'd0, s[7]}, 32'd0);
      chk("R4 read data value", {hi, lo}, m_rd);

      // R9 carry across halves
      set_addr(32'h0001_FFFC);
      run(4'h9, 32'h0BAD_F00D, 2'b00);
      chk("R9 carry into high half", m_addr, 32'h0002_0000);
      // R9 no increment on error
      run(4'hB, 32'h0, 2'b10);
      run(4'h9, 32'h1, 2'b11);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [3:0] cmd; logic [1:0] r;
         cmd = 4'h8 | 4'($urandom % 4);
         r = ($urandom % 5 == 0) ? 2'($urandom % 2 + 2) : 2'b00;
         if ($urandom % 3 == 0) set_addr({$urandom} & 32'hFFFF_FFFC);
         run(cmd, $urandom, r);
      end

      // R8 sticky / write-one-to-clear
      set_addr(32'h40);
      hw(3'd0, 16'hF000);
      hw(3'd1, 16'h0008); wait_idle(p, sb);
      hw(3'd1, 16'h000A); wait_idle(p, sb);
      s_resp = 2'b10;
      hw(3'd1, 16'h0008); wait_idle(p, sb);
      s_resp = 2'b00;
      hr(3'd0, s);
      chk("R8 three sticky flags", {16'd0, s[15:12]}, 32'hD);
      hw(3'd0, 16'h4000);
      hr(3'd0, s);
      chk("R8 one cleared, others kept", {16'd0, s[15:12]}, 32'h9);
      hw(3'd0, 16'h0000);
      hr(3'd0, s);
      chk("R8 zero write keeps flags", {16'd0, s[15:12]}, 32'h9);

      // R12 interrupt gating
      hw(3'd1, 16'h8000);
      @(negedge clk);
      chk("R12 irq with read-complete enabled", {31'd0, irq}, 32'd1);
      hw(3'd1, 16'h4000);
      @(negedge clk);
      chk("R12 irq masked", {31'd0, irq}, 32'd0);
      axi_irq_in = 1;
      repeat (3) @(negedge clk);
      hr(3'd0, s);
      chk("R12 status mirrors downstream line", {31'd0, s[11]}, 32'd1);
      chk("R12 downstream line masked", {31'd0, irq}, 32'd0);
      hw(3'd1, 16'h0800);
      @(negedge clk);
      chk("R12 downstream line enabled", {31'd0, irq}, 32'd1);
      axi_irq_in = 0;
      hw(3'd1, 16'h0000);
      hw(3'd0, 16'hF000);

      // R6 timeout with R10 ignored command while busy
      s_mute = 1;
      repeat (3) @(negedge clk);
      av = awv_cnt; wc = wr_cnt;
      hw(3'd1, 16'h000A);
      hw(3'd1, 16'h0008);
      hr(3'd1, c);
      chk("R10 stored command unchanged", {28'd0, c[3:0]}, 32'hA);
      wait_idle(p, sb);
      chk("R6 timeout latency", {31'd0, (p >= TMO - 4 && p <= TMO + 2)}, 32'd1);
      hr(3'd0, s);
      chk("R6 timeout flag only", {16'd0, s[15:12]}, 32'h2);
      chk("R10 no write launched while busy", awv_cnt, av);
      chk("R6 bus idle after timeout", {28'd0, m_arvalid, m_rready, m_awvalid, m_wvalid}, 32'd0);
      hr(3'd2, lo); hr(3'd3, hi);
      chk("R9 no increment on timeout", {hi, lo}, m_addr);
      s_mute = 0;
      repeat (6) @(negedge clk);
      chk("R6 no late write", wr_cnt, wc);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule